// File: doc/BRIEF.md
# ADC Result Byte Formatter

This block sits between an analog-to-digital converter core and a byte-wide CPU register read port. Each time the converter signals completion with a one-cycle strobe, the 10-bit result is split into a high byte and a low byte. The split follows one of three alignments chosen by a mode input: right-aligned, unsigned left-aligned, or signed left-aligned. The signed form is the left-aligned layout with the result's top bit inverted, which turns an offset-binary sample into two's complement.

Software reads the high byte first and the low byte second. A high-byte read locks the pair. While the lock is held, the low byte cannot change, and every conversion that completes is thrown away and flagged by a one-cycle overrun pulse. The low-byte read releases the lock. A result-valid flag tells software that a fresh, unread result is waiting. The alignment is applied when a result is stored, so a stored pair never mixes two layouts.

Top module: `adc_result_fmt`

## Requirements
- R1: With mode 00, the high byte (address 0) holds result bits 9..8 in bits 1..0 and zero in bits 7..2, and the low byte (address 1) holds result bits 7..0.
- R2: With mode 01, the high byte holds result bits 9..2 unchanged, and the low byte holds result bits 1..0 in bits 7..6 and zero in bits 5..0.
- R3: With mode 10, the layout is that of mode 01, except that high byte bit 7 is the inverse of result bit 9.
- R4: Mode 11 produces the same layout as mode 00.
- R5: When no lock is held and no high-byte read happens in the same cycle, a completion strobe loads both bytes. After that clock edge, result_valid is 1.
- R6: A high-byte read sets the lock. While the lock is held, completions are discarded, and both stored bytes keep their values.
- R7: Each discarded completion produces an overrun pulse of exactly one cycle, in the cycle after the strobe.
- R8: A low-byte read clears the lock and clears result_valid, unless that same edge loads a new result.
- R9: A low-byte read with no lock held returns the stored low byte and leaves the lock clear, so the next completion is stored.
- R10: rd_data shows the addressed byte in the cycle after the edge that samples rd_en. It holds its value when no read is made.
- R11: Reset clears the lock, result_valid, overrun and rd_data. It leaves the stored bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle completion strobe from the converter |
| conv_result | input | 10 | Conversion result, valid with conv_done |
| align_mode | input | 2 | 00 right, 01 left unsigned, 10 left signed, 11 right |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 1 | 0 selects the high byte, 1 selects the low byte |
| rd_data | output | 8 | Registered read data |
| overrun | output | 1 | One-cycle pulse per discarded result |
| result_valid | output | 1 | An unread result is stored |

## Verification
Three results follow the clock edge that samples their cause: a stored result, the lock state and the overrun pulse are all visible one cycle after the strobe or the read, and rd_data likewise lags rd_en by one cycle. The bench drives every input on the falling edge and lets exactly one rising edge pass. It samples on the next falling edge, which is the first point where each of these results is due. To confirm that the overrun pulse lasts a single cycle, the bench checks the flag again one idle cycle later. To confirm that a discarded result changed neither byte, the bench reads back both bytes after the lock has been released.

// File: rtl/adc_fmt_pkg.sv
`timescale 1ns/1ps
package adc_fmt_pkg;
  typedef enum logic [1:0] {
    ALIGN_RIGHT      = 2'b00,
    ALIGN_LEFT_UNS   = 2'b01,
    ALIGN_LEFT_SGN   = 2'b10,
    ALIGN_RIGHT_ALT  = 2'b11
  } align_e;

  // Byte addresses inside the register window
  localparam logic ADDR_HI = 1'b0;
  localparam logic ADDR_LO = 1'b1;
endpackage

// File: rtl/adc_fmt_align.sv
`timescale 1ns/1ps
module adc_fmt_align
  import adc_fmt_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic [RES_W-1:0]  result,
  input  logic [1:0]        mode,
  output logic [BYTE_W-1:0] hi_byte,
  output logic [BYTE_W-1:0] lo_byte
);
  localparam int PAIR_W = 2 * BYTE_W;
  localparam int PAD_W  = PAIR_W - RES_W;

  logic [PAIR_W-1:0] right_pair;
  logic [PAIR_W-1:0] left_pair;
  logic [RES_W-1:0]  signed_res;

  // Signed form: invert the result MSB (offset binary to two's complement)
  assign signed_res = {~result[RES_W-1], result[RES_W-2:0]};

  generate
    if (PAD_W > 0) begin : g_pad
      assign right_pair = {{PAD_W{1'b0}}, result};
    end else begin : g_nopad
      assign right_pair = result;
    end
  endgenerate

  always_comb begin
    left_pair = '0;
    unique case (align_e'(mode))
      ALIGN_LEFT_UNS: left_pair[PAIR_W-1 -: RES_W] = result;
      ALIGN_LEFT_SGN: left_pair[PAIR_W-1 -: RES_W] = signed_res;
      default:        left_pair = '0;
    endcase
  end

  always_comb begin
    if (mode == ALIGN_LEFT_UNS || mode == ALIGN_LEFT_SGN) begin
      hi_byte = left_pair[PAIR_W-1 -: BYTE_W];
      lo_byte = left_pair[BYTE_W-1:0];
    end else begin
      hi_byte = right_pair[PAIR_W-1 -: BYTE_W];
      lo_byte = right_pair[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/adc_fmt_lock.sv
`timescale 1ns/1ps
module adc_fmt_lock
  import adc_fmt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic conv_done,
  input  logic rd_en,
  input  logic rd_addr,
  output logic load,
  output logic locked,
  output logic overrun,
  output logic result_valid
);
  logic hi_rd, lo_rd, lock_q, ovr_q, vld_q;

  assign hi_rd = rd_en && (rd_addr == ADDR_HI);
  assign lo_rd = rd_en && (rd_addr == ADDR_LO);
  // A high read in the same cycle also blocks the load so the pair stays coherent
  assign load  = conv_done && !lock_q && !hi_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      ovr_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      if (hi_rd)      lock_q <= 1'b1;
      else if (lo_rd) lock_q <= 1'b0;
      ovr_q <= conv_done && !load;
      if (load)       vld_q <= 1'b1;
      else if (lo_rd) vld_q <= 1'b0;
    end
  end

  assign locked       = lock_q;
  assign overrun      = ovr_q;
  assign result_valid = vld_q;
endmodule

// File: rtl/adc_fmt_regs.sv
`timescale 1ns/1ps
module adc_fmt_regs
  import adc_fmt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] hi_in,
  input  logic [BYTE_W-1:0] lo_in,
  input  logic              rd_en,
  input  logic              rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0] hi_q, lo_q, rd_q;

  // Data bytes carry no reset
  always_ff @(posedge clk) begin
    if (load) begin
      hi_q <= hi_in;
      lo_q <= lo_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= (rd_addr == ADDR_LO) ? lo_q : hi_q;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/adc_result_fmt.sv
`timescale 1ns/1ps
module adc_result_fmt #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  input  logic [1:0]        align_mode,
  input  logic              rd_en,
  input  logic              rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              overrun,
  output logic              result_valid
);
  logic [BYTE_W-1:0] fmt_hi, fmt_lo;
  logic              load_w, lock_w;

  adc_fmt_align #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_align (
    .result  (conv_result),
    .mode    (align_mode),
    .hi_byte (fmt_hi),
    .lo_byte (fmt_lo)
  );

  adc_fmt_lock u_lock (
    .clk          (clk),
    .rst          (rst),
    .conv_done    (conv_done),
    .rd_en        (rd_en),
    .rd_addr      (rd_addr),
    .load         (load_w),
    .locked       (lock_w),
    .overrun      (overrun),
    .result_valid (result_valid)
  );

  adc_fmt_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .load    (load_w),
    .hi_in   (fmt_hi),
    .lo_in   (fmt_lo),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/adc_result_fmt_chk.sv
`timescale 1ns/1ps
module adc_result_fmt_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              conv_done,
  input logic              rd_en,
  input logic              rd_addr,
  input logic [BYTE_W-1:0] rd_data,
  input logic              overrun,
  input logic              result_valid,
  input logic              locked
);
  logic hi_rd, lo_rd;
  assign hi_rd = rd_en && !rd_addr;
  assign lo_rd = rd_en && rd_addr;

  assert_store_sets_valid_R5: assert property (@(posedge clk) disable iff (rst)
    (conv_done && !locked && !hi_rd) |=> result_valid);

  assert_high_read_locks_R6: assert property (@(posedge clk) disable iff (rst)
    hi_rd |=> locked);

  assert_drop_when_locked_R7: assert property (@(posedge clk) disable iff (rst)
    (conv_done && (locked || hi_rd)) |=> overrun);

  assert_no_spurious_overrun_R7: assert property (@(posedge clk) disable iff (rst)
    !conv_done |=> !overrun);

  assert_low_read_releases_R8: assert property (@(posedge clk) disable iff (rst)
    (lo_rd && locked) |=> (!locked && !result_valid));

  assert_unlocked_low_read_R9: assert property (@(posedge clk) disable iff (rst)
    (lo_rd && !locked) |=> !locked);

  assert_rdata_holds_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> (!locked && !overrun && !result_valid && rd_data == '0));
endmodule

bind adc_result_fmt adc_result_fmt_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .conv_done    (conv_done),
  .rd_en        (rd_en),
  .rd_addr      (rd_addr),
  .rd_data      (rd_data),
  .overrun      (overrun),
  .result_valid (result_valid),
  .locked       (lock_w)
);

// File: tb/adc_result_fmt_bench.sv
`timescale 1ns/1ps
module adc_result_fmt_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       conv_done = 1'b0;
  logic [9:0] conv_result = '0;
  logic [1:0] align_mode = 2'b00;
  logic       rd_en = 1'b0;
  logic       rd_addr = 1'b0;
  logic [7:0] rd_data;
  logic       overrun, result_valid;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_result_fmt u_adc_result_fmt (
    .clk(clk), .rst(rst), .conv_done(conv_done), .conv_result(conv_result),
    .align_mode(align_mode), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .overrun(overrun), .result_valid(result_valid)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic convert(input logic [9:0] v);
    conv_done = 1'b1; conv_result = v;
    tick();
    conv_done = 1'b0;
  endtask

  task automatic read_reg(input logic a, output logic [7:0] d);
    rd_en = 1'b1; rd_addr = a;
    tick();
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic expect_pair(input string req, input logic [7:0] eh, input logic [7:0] el);
    logic [7:0] d;
    read_reg(1'b0, d); chk(req, d, eh);
    read_reg(1'b1, d); chk(req, d, el);
  endtask

  task automatic t_reset();
    chk("R11 rd_data", rd_data, 8'h00);
    chk("R11 valid", {7'd0, result_valid}, 8'h00);
    chk("R11 overrun", {7'd0, overrun}, 8'h00);
  endtask

  task automatic t_modes();
    align_mode = 2'b00; convert(10'h2A5);
    chk("R5 valid after store", {7'd0, result_valid}, 8'h01);
    expect_pair("R1 right", 8'h02, 8'hA5);
    chk("R8 valid cleared", {7'd0, result_valid}, 8'h00);
    align_mode = 2'b01; convert(10'h2A5);
    expect_pair("R2 left unsigned", 8'hA9, 8'h40);
    align_mode = 2'b10; convert(10'h2A5);
    expect_pair("R3 left signed", 8'h29, 8'h40);
    align_mode = 2'b10; convert(10'h0FF);
    expect_pair("R3 signed low half", 8'hBF, 8'hC0);
    align_mode = 2'b11; convert(10'h3C7);
    expect_pair("R4 mode 11", 8'h03, 8'hC7);
  endtask

  task automatic t_lock();
    logic [7:0] d;
    align_mode = 2'b00; convert(10'h3C7);
    read_reg(1'b0, d); chk("R10 high byte", d, 8'h03);
    align_mode = 2'b01;
    convert(10'h0AA);
    chk("R7 overrun pulse", {7'd0, overrun}, 8'h01);
    tick();
    chk("R7 pulse one cycle", {7'd0, overrun}, 8'h00);
    read_reg(1'b1, d); chk("R6 low frozen", d, 8'hC7);
    chk("R8 valid cleared", {7'd0, result_valid}, 8'h00);
    expect_pair("R6 dropped result not stored", 8'h03, 8'hC7);
    align_mode = 2'b00; convert(10'h0AA);
    chk("R8 unlocked store no overrun", {7'd0, overrun}, 8'h00);
    expect_pair("R8 store after release", 8'h00, 8'hAA);
  endtask

  task automatic t_low_first();
    logic [7:0] d;
    align_mode = 2'b00; convert(10'h155);
    read_reg(1'b1, d); chk("R9 low without high", d, 8'h55);
    convert(10'h2A5);
    chk("R9 no lock left", {7'd0, overrun}, 8'h00);
    expect_pair("R9 next stored", 8'h02, 8'hA5);
  endtask

  task automatic t_reset_keeps();
    align_mode = 2'b00; convert(10'h1E4);
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R11 valid after reset", {7'd0, result_valid}, 8'h00);
    chk("R11 rd_data after reset", rd_data, 8'h00);
    expect_pair("R11 bytes kept", 8'h01, 8'hE4);
  endtask

  initial begin
    @(negedge clk); tick(); tick();
    rst = 1'b0;
    t_reset();
    t_modes();
    t_lock();
    t_low_first();
    t_reset_keeps();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule